// File: doc/BRIEF.md
# Phase-Synchronized PWM Channel

This block is one pulse-width modulation channel. Its timebase counts up from zero to a programmed period and then wraps, and a two-bit action code for each of two counter events drives a single output. The two events are the counter at zero and the counter equal to the active compare value. The compare value is written into a shadow register. It reaches the active compare register only when the counter passes zero, so a duty change never cuts a pulse short in the middle of a period.

Channels can be chained into a group that holds fixed phase offsets. Each channel takes a sync input and drives a sync output. A channel that is set to emit sync at zero acts as the leader. A follower with phase loading enabled reloads its counter from its phase register on each sync pulse. A follower with zero-sync disabled forwards its sync input to the next channel in the chain. A two-stage prescaler produces the timebase tick from the system clock.

Top module: `pwm_channel`

## Requirements
- R1: On each timebase tick the counter advances by one. When the counter is greater than or equal to the period, the tick returns it to 0 instead, so the output period is period+1 ticks.
- R2: When phase loading is enabled (control bit 0 = 1), a high sync_in loads the phase register into the counter at the next clock edge, ahead of any tick. In a leader/follower pair with equal periods, the follower's rising edge comes period+2-phase clock cycles after the leader's.
- R3: When phase loading is disabled, sync_in has no effect on the counter.
- R4: With control bit 1 = 1, sync_out is high for the one clock of each tick at which the counter is 0. With control bit 1 = 0, sync_out follows sync_in in the same cycle.
- R5: A write to the compare address updates only the shadow register. The active compare value takes the shadow value at the edge that ends a zero event, so the duty cycle in progress is kept.
- R6: Action codes are 0 = no action, 1 = drive low, 2 = drive high, 3 = toggle. The zero action is control bits [9:8] and the compare action is control bits [11:10]. pwm_out is registered and changes at the edge that ends the event's cycle.
- R7: When a zero event and a compare event fall on the same tick, a compare action other than 0 wins. With zero=high and compare=low, a compare of 0 gives a constant low output, a compare above the period gives a constant high output, and otherwise the output is high for exactly compare ticks per period.
- R8: Control bits [4:3] (hs) select a first divide factor of 1 when hs is 0 and 2*hs otherwise. Control bits [7:5] (g) select a second factor of 2^g. The timebase ticks once every product of the two factors clocks.
- R9: Writing the control address with bit 2 = 1 forces the counter to 0 at that write's edge, ahead of a sync load or a tick. This bit is not stored.
- R10: The register write port decodes wr_addr as 0 = period, 1 = phase, 2 = compare shadow, 3 = control. After reset all registers and pwm_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Sync pulse from the previous channel |
| sync_out | output | 1 | Sync pulse to the next channel |
| pwm_out | output | 1 | PWM output |

## Verification
The in-line assertions check the following on every cycle: the counter wraps once it reaches the period, a sync load delivers the phase value, sync is ignored with loading off, a software clear forces zero, the active compare changes only after a zero event, and a compare clear forces the output low. Some properties emerge over a whole period and only the bench scenarios can show them. These are the duty cycle for each compare value, the spacing between the rising edges of chained channels, the delayed effect of a compare write, the tick rate set by the prescaler, and sync forwarding along a chain.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam int HS_W  = 2;
    localparam int DIV_W = 3;
    localparam int GEN_W = 2 ** DIV_W;
    localparam int PS_W  = HS_W + 1 + GEN_W;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        ADDR_PRD = 2'd0,
        ADDR_PHS = 2'd1,
        ADDR_CMP = 2'd2,
        ADDR_CTL = 2'd3
    } addr_e;

    typedef struct packed {
        act_e             act_cmp;
        act_e             act_zero;
        logic [DIV_W-1:0] div_sel;
        logic [HS_W-1:0]  hs_sel;
        logic             sync_zero;
        logic             phase_en;
    } ctl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] prd_o,
    output logic [CNT_W-1:0] phs_o,
    output logic [CNT_W-1:0] shd_o,
    output ctl_t             ctl_o,
    output logic             clr_o
);
    typedef struct packed {
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] phs;
        logic [CNT_W-1:0] shd;
        ctl_t             ctl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr_e'(wr_addr))
                ADDR_PRD: r_d.prd = wr_data;
                ADDR_PHS: r_d.phs = wr_data;
                ADDR_CMP: r_d.shd = wr_data;
                ADDR_CTL: begin
                    r_d.ctl.act_cmp   = act_e'(wr_data[11:10]);
                    r_d.ctl.act_zero  = act_e'(wr_data[9:8]);
                    r_d.ctl.div_sel   = wr_data[7:5];
                    r_d.ctl.hs_sel    = wr_data[4:3];
                    r_d.ctl.sync_zero = wr_data[1];
                    r_d.ctl.phase_en  = wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign prd_o = r_q.prd;
    assign phs_o = r_q.phs;
    assign shd_o = r_q.shd;
    assign ctl_o = r_q.ctl;
    assign clr_o = wr_en && (addr_e'(wr_addr) == ADDR_CTL) && wr_data[2];
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HS_W-1:0]  hs_sel,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick_o
);
    logic [HS_W:0]    hs_fac;
    logic [GEN_W-1:0] gen_fac;
    logic [PS_W-1:0]  lim;
    logic [PS_W-1:0]  cnt_d, cnt_q;

    always_comb begin
        hs_fac  = (hs_sel == '0) ? (HS_W+1)'(1) : {hs_sel, 1'b0};
        gen_fac = GEN_W'(1) << div_sel;
        lim     = PS_W'(hs_fac) * PS_W'(gen_fac) - PS_W'(1);
        tick_o  = (cnt_q >= lim);
        cnt_d   = tick_o ? '0 : cnt_q + PS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_i,
    input  logic             sync_in,
    input  logic             phase_en_i,
    input  logic [CNT_W-1:0] prd_i,
    input  logic [CNT_W-1:0] phs_i,
    output logic [CNT_W-1:0] ctr_o
);
    logic [CNT_W-1:0] ctr_d, ctr_q;
    logic             load;

    always_comb begin
        load  = sync_in && phase_en_i && !clr_i;
        ctr_d = ctr_q;
        if (clr_i)            ctr_d = '0;
        else if (load)        ctr_d = phs_i;
        else if (tick)        ctr_d = (ctr_q >= prd_i) ? '0 : ctr_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign ctr_o = ctr_q;

    // R1
    wrap_at_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_i && !load && ctr_q >= prd_i) |=> (ctr_q == '0));

    // R2
    phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctr_q == $past(phs_i)));

    // R3
    sync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !phase_en_i && !clr_i && !tick) |=> $stable(ctr_q));

    // R9
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (ctr_q == '0));
endmodule

// File: rtl/pwm_action.sv
module pwm_action
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] ctr_i,
    input  logic [CNT_W-1:0] shd_i,
    input  act_e             act_zero_i,
    input  act_e             act_cmp_i,
    output logic             zero_evt_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp_act;
        logic             pwm;
    } act_st_t;

    act_st_t s_d, s_q;
    logic    cmp_evt;

    function automatic logic apply_act(input act_e a, input logic cur);
        unique case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_TGL:  return ~cur;
            default:  return cur;
        endcase
    endfunction

    always_comb begin
        zero_evt_o = tick && (ctr_i == '0);
        cmp_evt    = tick && (ctr_i == s_q.cmp_act);
        s_d        = s_q;
        if (cmp_evt && act_cmp_i != ACT_NONE) s_d.pwm = apply_act(act_cmp_i, s_q.pwm);
        else if (zero_evt_o)                  s_d.pwm = apply_act(act_zero_i, s_q.pwm);
        if (zero_evt_o) s_d.cmp_act = shd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = s_q.pwm;

    // R5
    shadow_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.cmp_act) |-> $past(zero_evt_o));

    // R7
    cmp_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_evt && act_cmp_i == ACT_LOW) |=> !pwm_o);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             pwm_out
);
    logic [CNT_W-1:0] prd, phs, shd, ctr;
    ctl_t             ctl;
    logic             clr, tick, zero_evt;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prd_o(prd), .phs_o(phs), .shd_o(shd),
        .ctl_o(ctl), .clr_o(clr)
    );

    pwm_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .hs_sel(ctl.hs_sel),
        .div_sel(ctl.div_sel), .tick_o(tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr_i(clr),
        .sync_in(sync_in), .phase_en_i(ctl.phase_en), .prd_i(prd),
        .phs_i(phs), .ctr_o(ctr)
    );

    pwm_action #(.CNT_W(CNT_W)) u_act (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctr_i(ctr), .shd_i(shd),
        .act_zero_i(ctl.act_zero), .act_cmp_i(ctl.act_cmp),
        .zero_evt_o(zero_evt), .pwm_o(pwm_out)
    );

    assign sync_out = ctl.sync_zero ? zero_evt : sync_in;
endmodule

// File: tb/pwm_channel_tb.sv
module pwm_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VEC [6][3] = '{
        '{9, 4, 4}, '{9, 0, 0}, '{9, 12, 10},
        '{9, 9, 9}, '{5, 1, 1}, '{15, 8, 8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sync_lead, sync_fol, pwm_lead, pwm_fol;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_channel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(1'b0), .sync_out(sync_lead), .pwm_out(pwm_lead)
    );

    pwm_channel u_follow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_lead), .sync_out(sync_fol), .pwm_out(pwm_fol)
    );

    function automatic logic [15:0] ctl(input int ac, input int az, input int dv,
                                        input int hs, input int cl, input int sz, input int pe);
        return 16'((ac << 10) | (az << 8) | (dv << 5) | (hs << 3) | (cl << 2) | (sz << 1) | pe);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit to_b, input logic [1:0] a, input logic [15:0] d);
        wr_addr = a; wr_data = d;
        if (to_b) wr_en_b = 1'b1; else wr_en_a = 1'b1;
        @(negedge clk);
        wr_en_a = 1'b0; wr_en_b = 1'b0;
    endtask

    task automatic wait_sync(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (sync_lead) begin ok = 1'b1; break; end
        end
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_lead) hi++;
        end
    endtask

    task automatic measure_lag(output int lag);
        logic prev;
        lag = -1;
        prev = pwm_lead;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!prev && pwm_lead) begin lag = 0; break; end
            prev = pwm_lead;
        end
        if (lag == 0) begin
            prev = pwm_fol;
            lag = -1;
            for (int k = 1; k < 200; k++) begin
                @(negedge clk);
                if (!prev && pwm_fol) begin lag = k; break; end
                prev = pwm_fol;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int  hi, lag, t;
        bit  ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(pwm_lead == 1'b0, "R10 reset pwm_out", int'(pwm_lead), 0);
        check(sync_lead == 1'b0, "R10 reset sync_out", int'(sync_lead), 0);

        // R1 R6 R7 R10 duty table
        wr(0, 2'd3, ctl(1, 2, 0, 0, 0, 1, 0));
        foreach (VEC[i]) begin
            wr(0, 2'd0, 16'(VEC[i][0]));
            wr(0, 2'd2, 16'(VEC[i][1]));
            repeat (40) @(negedge clk);
            count_high(VEC[i][0] + 1, hi);
            check(hi == VEC[i][2], $sformatf("R1 R7 R10 duty prd=%0d cmp=%0d", VEC[i][0], VEC[i][1]),
                  hi, VEC[i][2]);
        end

        // R6 toggle on zero, no compare action
        wr(0, 2'd0, 16'd4);
        wr(0, 2'd3, ctl(0, 3, 0, 0, 0, 1, 0));
        repeat (12) @(negedge clk);
        count_high(10, hi);
        check(hi == 5, "R6 toggle on zero", hi, 5);

        // R5 shadow compare loads only at zero
        wr(0, 2'd3, ctl(1, 2, 0, 0, 0, 1, 0));
        wr(0, 2'd0, 16'd9);
        wr(0, 2'd2, 16'd4);
        repeat (40) @(negedge clk);
        wait_sync(ok);
        check(ok, "R4 leader sync at zero", int'(ok), 1);
        wr(0, 2'd2, 16'd7);
        repeat (5) @(negedge clk);
        check(pwm_lead == 1'b0, "R5 old compare kept in period", int'(pwm_lead), 0);
        repeat (10) @(negedge clk);
        check(pwm_lead == 1'b1, "R5 new compare after zero", int'(pwm_lead), 1);
        repeat (2) @(negedge clk);
        check(pwm_lead == 1'b0, "R5 new compare clears", int'(pwm_lead), 0);

        // R8 prescaler: factor 2*1 * 2^1 = 4
        wr(0, 2'd0, 16'd4);
        wr(0, 2'd2, 16'd2);
        wr(0, 2'd3, ctl(1, 2, 1, 1, 0, 1, 0));
        repeat (60) @(negedge clk);
        count_high(20, hi);
        check(hi == 8, "R8 prescaled duty", hi, 8);
        wait_sync(ok);
        t = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            t++;
            if (sync_lead) break;
        end
        check(t == 20, "R8 R4 prescaled sync spacing", t, 20);

        // R2 chained pair, phase 3
        wr(0, 2'd3, ctl(1, 2, 0, 0, 0, 1, 0));
        wr(0, 2'd0, 16'd9);
        wr(0, 2'd2, 16'd4);
        wr(1, 2'd0, 16'd9);
        wr(1, 2'd2, 16'd4);
        wr(1, 2'd1, 16'd3);
        wr(1, 2'd3, ctl(1, 2, 0, 0, 0, 0, 1));
        repeat (40) @(negedge clk);
        measure_lag(lag);
        check(lag == 8, "R2 follower lag phase 3", lag, 8);
        wait_sync(ok);
        check(sync_fol == 1'b1, "R4 sync passthrough", int'(sync_fol), 1);

        // R2 phase 6
        wr(1, 2'd1, 16'd6);
        repeat (30) @(negedge clk);
        measure_lag(lag);
        check(lag == 5, "R2 follower lag phase 6", lag, 5);

        // R3 R9 loading off, counter cleared in leader zero cycle
        wait_sync(ok);
        wr(1, 2'd3, ctl(1, 2, 0, 0, 1, 0, 0));
        repeat (35) @(negedge clk);
        measure_lag(lag);
        check(lag == 1, "R3 R9 sync ignored after clear", lag, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule